// File: doc/BRIEF.md
# Adaptive Pre-Charge Gate Current Sequencer

This block sequences the gate current of one external power transistor for a single switching direction. Each rising PWM edge starts three current phases in fixed order. A pre-charge phase moves the gate quickly towards its plateau. A drive phase applies the slew-control current while the switch node moves. A post-charge phase finishes charging the gate after the slew. The active current code is driven out to an analog current DAC, which lies outside this block, together with a phase indicator. A second instance covers the opposite switching direction.

The length of the pre-charge phase is a programmed fraction of the programmed propagation delay, and it is timed only. The slew-detect comparator never ends it, because comparator latency inside the slew window would disturb the slew. Instead, the block measures how many cycles after the edge the switch node began to slew. Once per PWM cycle it moves the pre-charge code by one step towards the value that brings that delay onto the target. A small dead band holds the code when the error is small, and the code is clamped to a programmable window. If no slew is seen before the drive phase runs out, the code is raised and a one-cycle missed-slew flag is raised.

Top module: `gate_precharge_ctrl`

## Requirements
- R1: After reset `phase_o` is 0 (idle), `cur_code_o` is 0, `miss_o` is 0, and the stored pre-charge code is INIT_CODE (8).
- R2: A rising edge on `pwm_i` seen while idle starts an edge sequence. The pre-charge phase (`phase_o`=1, `cur_code_o` = stored pre-charge code) lasts P = (`tdly_i` * `frac_i`) >> 4 cycles. When P is 0 the sequence enters the drive phase directly.
- R3: The drive phase (`phase_o`=2) drives `cur_code_o` = `drv_code_i`. The change from pre-charge to drive depends only on P and not on either comparator input.
- R4: Drive ends in post-charge (`phase_o`=3, `cur_code_o` = `pst_code_i`) in two cases: the cycle after `slew_done_i` is sampled high once a slew start has already been captured, or after DRV_MAX (64) drive cycles. Post-charge lasts while `pwm_i` stays high.
- R5: The measured delay is the value of a counter that is 0 in the first cycle after the launch and counts up by one per cycle, taken in the first cycle of pre-charge or drive in which `slew_start_i` is high.
- R6: When drive ends and the measured delay is greater than `tdly_i` + 1, the pre-charge code rises by STEP (1).
- R7: When drive ends and the measured delay + 1 is less than `tdly_i`, the pre-charge code falls by STEP.
- R8: When drive ends and the measured delay lies within one cycle of `tdly_i`, the pre-charge code is unchanged.
- R9: After each update the pre-charge code is clamped into [`code_min_i`, `code_max_i`].
- R10: When drive ends with no slew start captured, the code rises by STEP (then clamped) and `miss_o` is high for exactly the following cycle.
- R11: `pwm_i` sampled low in any phase returns the block to idle (`phase_o`=0, `cur_code_o`=0) and makes no code update for that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command; a rising edge launches a sequence |
| slew_start_i | input | 1 | Comparator: switch node has begun to slew |
| slew_done_i | input | 1 | Comparator: switch node slew has finished |
| tdly_i | input | 8 | Target propagation delay in cycles |
| frac_i | input | 4 | Pre-charge share of the target, in sixteenths |
| drv_code_i | input | 6 | Current code for the drive phase |
| pst_code_i | input | 6 | Current code for the post-charge phase |
| code_min_i | input | 6 | Lower bound of the pre-charge code |
| code_max_i | input | 6 | Upper bound of the pre-charge code |
| cur_code_o | output | 6 | Active current code |
| phase_o | output | 2 | 0 idle, 1 pre-charge, 2 drive, 3 post-charge |
| miss_o | output | 1 | One-cycle flag: no slew seen on the last edge |

## Verification
The assertions take for granted that `code_min_i` does not exceed `code_max_i` and that the configuration inputs stay steady from launch until the code update. They also assume `slew_done_i` only has meaning after `slew_start_i`. The bench changes the configuration only while `pwm_i` is low, always draws the minimum no larger than the maximum, and raises `slew_done_i` no earlier than `slew_start_i`. Random edges vary the target, fraction, slew timing and bounds. Directed edges hit the dead-band edges, a zero-length pre-charge, clamping at both bounds, missed slews and aborted edges.

// File: rtl/gate_precharge_pkg.sv
package gate_precharge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_DRV  = 2'd2,
    PH_PST  = 2'd3
  } phase_e;

endpackage

// File: rtl/gpc_edge_seq.sv
module gpc_edge_seq
  import gate_precharge_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int FRAC_W  = 4,
  parameter int CNT_W   = 10,
  parameter int DRV_MAX = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic [DLY_W-1:0] tdly_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic             seen_i,
  input  logic             slew_done_i,
  output phase_e           state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             launch_o,
  output logic             exit_o
);
  localparam int DRV_W = (DRV_MAX > 1) ? $clog2(DRV_MAX) : 1;
  localparam int PROD_W = DLY_W + FRAC_W;

  phase_e           state_q, state_d;
  logic             pwm_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DRV_W-1:0] drv_q;
  logic [PROD_W-1:0] prod;
  logic [DLY_W-1:0] pre_len;
  logic             pre_last;
  logic             drv_last;

  assign prod     = PROD_W'(tdly_i) * PROD_W'(frac_i);
  assign pre_len  = DLY_W'(prod >> FRAC_W);
  assign pre_last = (cnt_q == CNT_W'(pre_len) - CNT_W'(1));
  assign drv_last = (drv_q == DRV_W'(DRV_MAX - 1));
  assign launch_o = (state_q == PH_IDLE) && pwm_i && !pwm_q;
  assign exit_o   = (state_q == PH_DRV) && pwm_i && ((seen_i && slew_done_i) || drv_last);

  always_comb begin
    state_d = state_q;
    if (!pwm_i) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE: if (launch_o) state_d = (pre_len == '0) ? PH_DRV : PH_PRE;
        PH_PRE:  if (pre_last) state_d = PH_DRV;
        PH_DRV:  if (exit_o) state_d = PH_PST;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      pwm_q   <= 1'b0;
      cnt_q   <= '0;
      drv_q   <= '0;
    end else begin
      state_q <= state_d;
      pwm_q   <= pwm_i;
      if (launch_o) begin
        cnt_q <= '0;
        drv_q <= '0;
      end else if (pwm_i && (state_q == PH_PRE || state_q == PH_DRV)) begin
        if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
        if (state_q == PH_DRV && !drv_last) drv_q <= drv_q + DRV_W'(1);
      end
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  // R11
  pwm_low_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> state_q == PH_IDLE);
  // R4
  pst_from_drv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE || state_q == PH_PRE) |=> state_q != PH_PST);
  // R2
  pre_from_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_DRV || state_q == PH_PST) |=> state_q != PH_PRE);
  // R4
  drv_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_DRV && drv_last && pwm_i) |=> state_q == PH_PST);
endmodule

// File: rtl/gpc_delay_meas.sv
module gpc_delay_meas #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             active_i,
  input  logic             slew_start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             seen_o,
  output logic             seen_now_o,
  output logic [CNT_W-1:0] meas_now_o
);
  logic             seen_q;
  logic [CNT_W-1:0] meas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      meas_q <= '0;
    end else if (launch_i) begin
      seen_q <= 1'b0;
    end else if (active_i && !seen_q && slew_start_i) begin
      seen_q <= 1'b1;
      meas_q <= cnt_i;
    end
  end

  // capture visible in the same cycle, so a start on the last drive cycle still counts
  assign seen_o     = seen_q;
  assign seen_now_o = seen_q || (active_i && slew_start_i);
  assign meas_now_o = seen_q ? meas_q : cnt_i;

  // R5
  meas_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !launch_i) |=> (seen_q && $stable(meas_q)));
endmodule

// File: rtl/gpc_adapt.sv
module gpc_adapt #(
  parameter int CODE_W    = 6,
  parameter int DLY_W     = 8,
  parameter int CNT_W     = 10,
  parameter int INIT_CODE = 8,
  parameter int STEP      = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              seen_i,
  input  logic [CNT_W-1:0]  meas_i,
  input  logic [DLY_W-1:0]  tdly_i,
  input  logic [CODE_W-1:0] min_i,
  input  logic [CODE_W-1:0] max_i,
  output logic [CODE_W-1:0] code_o,
  output logic              miss_o
);
  localparam int W = ((CNT_W > DLY_W) ? CNT_W : DLY_W) + 2;
  localparam int CW = CODE_W + 1;

  logic [CODE_W-1:0] code_q, code_d;
  logic              miss_q;
  logic [W-1:0]      m_ext, t_ext;
  logic              late, early;
  logic [CW-1:0]     up, dn, raw;

  assign m_ext = W'(meas_i);
  assign t_ext = W'(tdly_i);
  assign late  = m_ext > t_ext + W'(1);
  assign early = m_ext + W'(1) < t_ext;
  assign up    = CW'(code_q) + CW'(STEP);
  assign dn    = (code_q < CODE_W'(STEP)) ? '0 : CW'(code_q) - CW'(STEP);

  always_comb begin
    if (!seen_i || late) raw = up;
    else if (early)      raw = dn;
    else                 raw = CW'(code_q);
    if (raw > CW'(max_i))      code_d = max_i;
    else if (raw < CW'(min_i)) code_d = min_i;
    else                       code_d = CODE_W'(raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_W'(INIT_CODE);
      miss_q <= 1'b0;
    end else begin
      miss_q <= upd_i && !seen_i;
      if (upd_i) code_q <= code_d;
    end
  end

  assign code_o = code_q;
  assign miss_o = miss_q;

  // R9
  code_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && min_i <= max_i) |=> (code_q >= $past(min_i) && code_q <= $past(max_i)));
  // R10
  miss_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q |=> !miss_q);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i) |=> $stable(code_q));
endmodule

// File: rtl/gate_precharge_ctrl.sv
module gate_precharge_ctrl
  import gate_precharge_pkg::*;
#(
  parameter int DLY_W     = 8,
  parameter int FRAC_W    = 4,
  parameter int CODE_W    = 6,
  parameter int DRV_MAX   = 64,
  parameter int INIT_CODE = 8,
  parameter int STEP      = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic              slew_start_i,
  input  logic              slew_done_i,
  input  logic [DLY_W-1:0]  tdly_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [CODE_W-1:0] drv_code_i,
  input  logic [CODE_W-1:0] pst_code_i,
  input  logic [CODE_W-1:0] code_min_i,
  input  logic [CODE_W-1:0] code_max_i,
  output logic [CODE_W-1:0] cur_code_o,
  output logic [1:0]        phase_o,
  output logic              miss_o
);
  localparam int CNT_W = DLY_W + 2;

  phase_e            state;
  logic [CNT_W-1:0]  cnt;
  logic              launch, exit_drv, seen, seen_now, active;
  logic [CNT_W-1:0]  meas_now;
  logic [CODE_W-1:0] pre_code;

  gpc_edge_seq #(
    .DLY_W(DLY_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .DRV_MAX(DRV_MAX)
  ) u_seq (
    .clk_i, .rst_ni, .pwm_i, .tdly_i, .frac_i,
    .seen_i(seen), .slew_done_i,
    .state_o(state), .cnt_o(cnt), .launch_o(launch), .exit_o(exit_drv)
  );

  assign active = pwm_i && (state == PH_PRE || state == PH_DRV);

  gpc_delay_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i, .rst_ni, .launch_i(launch), .active_i(active), .slew_start_i,
    .cnt_i(cnt), .seen_o(seen), .seen_now_o(seen_now), .meas_now_o(meas_now)
  );

  gpc_adapt #(
    .CODE_W(CODE_W), .DLY_W(DLY_W), .CNT_W(CNT_W),
    .INIT_CODE(INIT_CODE), .STEP(STEP)
  ) u_adapt (
    .clk_i, .rst_ni, .upd_i(exit_drv), .seen_i(seen_now), .meas_i(meas_now),
    .tdly_i, .min_i(code_min_i), .max_i(code_max_i),
    .code_o(pre_code), .miss_o
  );

  always_comb begin
    unique case (state)
      PH_PRE:  cur_code_o = pre_code;
      PH_DRV:  cur_code_o = drv_code_i;
      PH_PST:  cur_code_o = pst_code_i;
      default: cur_code_o = '0;
    endcase
  end

  assign phase_o = state;

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0) |-> (cur_code_o == '0));
  // R3
  drv_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2) |-> (cur_code_o == drv_code_i));
endmodule

// File: tb/tb_gate_precharge_ctrl.sv
module tb_gate_precharge_ctrl;
  localparam int DRV_MAX = 64;
  localparam int INIT    = 8;
  localparam int STEP    = 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwm_i = 1'b0, slew_start_i = 1'b0, slew_done_i = 1'b0;
  logic [7:0] tdly_i = 8'd10;
  logic [3:0] frac_i = 4'd8;
  logic [5:0] drv_code_i = 6'd20, pst_code_i = 6'd5;
  logic [5:0] code_min_i = 6'd0, code_max_i = 6'd63;
  logic [5:0] cur_code_o;
  logic [1:0] phase_o;
  logic       miss_o;

  gate_precharge_ctrl dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_ph, m_cnt, m_drv, m_code, m_meas;
  bit m_seen, m_pwmq, m_miss;
  string m_tag;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int clampc(int v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic model_adv();
    int pre_len, nph;
    bit exit_now, seen_now, late, early;
    int meas_now, raw;
    pre_len = (int'(tdly_i) * int'(frac_i)) >> 4;
    nph = m_ph;
    m_miss = 1'b0;
    if (!pwm_i) nph = 0;
    else if (m_ph == 0) begin
      if (!m_pwmq) begin
        m_cnt = 0; m_drv = 0; m_seen = 0;
        nph = (pre_len == 0) ? 2 : 1;
      end
    end else if (m_ph == 1 || m_ph == 2) begin
      seen_now = m_seen || slew_start_i;
      meas_now = m_seen ? m_meas : m_cnt;
      exit_now = (m_ph == 2) && ((m_seen && slew_done_i) || m_drv == DRV_MAX - 1);
      if (m_ph == 1 && m_cnt == pre_len - 1) nph = 2;
      if (exit_now) begin
        nph = 3;
        late  = meas_now > int'(tdly_i) + 1;
        early = meas_now + 1 < int'(tdly_i);
        if (!seen_now) begin raw = m_code + STEP; m_miss = 1'b1; m_tag = "R10"; end
        else if (late) begin raw = m_code + STEP; m_tag = "R5/R6"; end
        else if (early) begin raw = (m_code < STEP) ? 0 : m_code - STEP; m_tag = "R5/R7"; end
        else begin raw = m_code; m_tag = "R8"; end
        if (raw != clampc(raw, int'(code_min_i), int'(code_max_i))) m_tag = "R9";
        m_code = clampc(raw, int'(code_min_i), int'(code_max_i));
      end
      if (!m_seen && slew_start_i) begin m_seen = 1'b1; m_meas = m_cnt; end
      m_cnt++;
      if (m_ph == 2 && m_drv != DRV_MAX - 1) m_drv++;
    end
    m_ph = nph;
    m_pwmq = pwm_i;
  endtask

  // one cycle: check outputs against model, apply inputs, advance model
  task automatic step(bit p, bit ss, bit sd);
    int exp_code;
    string ptag;
    @(negedge clk_i);
    case (m_ph)
      1: begin exp_code = m_code; ptag = "R2"; end
      2: begin exp_code = int'(drv_code_i); ptag = "R3"; end
      3: begin exp_code = int'(pst_code_i); ptag = "R4"; end
      default: begin exp_code = 0; ptag = "R11"; end
    endcase
    chk(ptag, int'(phase_o), m_ph);
    chk((m_ph == 1) ? m_tag : ptag, int'(cur_code_o), exp_code);
    chk("R10", int'(miss_o), int'(m_miss));
    pwm_i = p; slew_start_i = ss; slew_done_i = sd;
    model_adv();
  endtask

  // d: slew start (cycle index after launch), w: slew width, ab: abort step or -1
  task automatic run_edge(int d, int w, int ab);
    int pst_n = 0;
    for (int j = 0; j < 400; j++) begin
      if (ab >= 0 && j == ab) break;
      step(1'b1, j >= d + 1, j >= d + 1 + w);
      if (m_ph == 3) pst_n++;
      if (pst_n >= 3) break;
    end
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic cfg(int t, int f, int lo, int hi);
    tdly_i = 8'(t); frac_i = 4'(f); code_min_i = 6'(lo); code_max_i = 6'(hi);
    drv_code_i = 6'($urandom_range(63)); pst_code_i = 6'($urandom_range(63));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_ph = 0; m_cnt = 0; m_drv = 0; m_code = INIT; m_meas = 0;
    m_seen = 0; m_pwmq = 0; m_miss = 0; m_tag = "R1";
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", int'(phase_o), 0);
    chk("R1", int'(cur_code_o), 0);
    chk("R1", int'(miss_o), 0);
    rst_ni = 1'b1;
    // R1 initial code visible in first pre-charge phase
    cfg(10, 8, 0, 63);
    run_edge(10, 4, -1);
    // R8 dead band: meas = target +1, -1, exact
    cfg(20, 4, 0, 63);
    run_edge(21, 3, -1);
    run_edge(19, 3, -1);
    run_edge(20, 3, -1);
    // R6 / R7 late and early
    run_edge(30, 2, -1);
    run_edge(5, 2, -1);
    // R2 zero-length pre-charge
    cfg(12, 0, 0, 63);
    run_edge(14, 2, -1);
    // R10 missed slew and R9 clamp at max
    cfg(10, 8, 2, 9);
    run_edge(1000, 1, -1);
    run_edge(1000, 1, -1);
    run_edge(1000, 1, -1);
    // R9 clamp at min
    cfg(60, 2, 7, 7);
    run_edge(3, 1, -1);
    cfg(60, 2, 5, 20);
    run_edge(3, 1, -1);
    run_edge(3, 1, -1);
    run_edge(3, 1, -1);
    // R11 aborts in pre-charge and drive
    cfg(40, 8, 0, 63);
    run_edge(50, 2, 10);
    run_edge(50, 2, 30);
    // R4 slew done coinciding with start
    run_edge(25, 0, -1);
    // random edges
    for (int e = 0; e < 300; e++) begin
      int lo, hi, t, d, ab;
      lo = $urandom_range(12);
      hi = $urandom_range(63, lo);
      t  = $urandom_range(60, 1);
      cfg(t, $urandom_range(15), lo, hi);
      d  = ($urandom_range(9) == 0) ? 1000 : $urandom_range(t + 20);
      ab = ($urandom_range(11) == 0) ? $urandom_range(t + 10, 1) : -1;
      run_edge(d, $urandom_range(12), ab);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule